// File: doc/BRIEF.md
# Capture-mode timer channel

This block is one counter channel of a timer used to measure when edges arrive on an input pin. A free-running up-counter advances on each cycle in which a count tick is present. Selected edges on input A copy the counter value into two capture registers, RA and then RB, always in that order. Software reads the captured values and works out pulse widths or periods from their difference.

The counter can be returned to zero by a trigger. A trigger can come from software, from a chosen edge on input A or input B, or from the counter reaching a programmed compare value RC. After the RB capture the channel can freeze the count until the next trigger, or it can turn its own count clock off. Sticky status flags report overflow, load overrun, compare match, both capture loads and the external trigger. Both input pins pass through a synchronizer before their edges are detected. In this mode the pins are inputs only.

Clock selection and register access are outside this block. The tick input carries the selected count clock, and plain configuration inputs stand in for the mode register.

Top module: `cap_timer_chan`

## Requirements
- R1: While reset is asserted, and directly after it, the counter, RA, RB and all status flags read zero and the count clock is off.
- R2: Counting and clock commands.
  - A clock-enable pulse turns the count clock on, and a clock-disable pulse turns it off.
  - When both pulses arrive in the same cycle, disable wins.
  - While the clock is on and the counter is not frozen, the counter rises by one on each cycle with tick high.
  - Without tick, the counter holds its value.
- R3: When the counter advances from its all-ones value it wraps to zero and sets the overflow flag (status bit 0).
- R4: Edge-select fields use the code 0 = none, 1 = rising, 2 = falling, 3 = both. A pin change applied before a clock edge is acted on at the third rising clock edge after it.
- R5: While the count clock is on, a matching edge of input A (field `cfg_ra_edge`) loads RA with the counter value and sets the RA-loaded flag (status bit 3).
- R6: Capture order and the RB load.
  - RB loads only on an edge that matches `cfg_rb_edge` and only after an RA load.
  - RA loads again only after that RB load, so the loads alternate RA, RB, RA.
  - An RB load sets the RB-loaded flag (status bit 4).
- R7: Loading RA or RB while its previous value has not yet been acknowledged by its read strobe sets the load-overrun flag (status bit 1).
- R8: Self-stop after the RB capture.
  - With `cfg_stop_on_rb` set, an RB load freezes the counter at the captured value until the next trigger, and the clock stays on.
  - With `cfg_dis_on_rb` set, an RB load turns the count clock off, and the counter also holds the captured value.
- R9: External trigger.
  - `cfg_trg_from_a` selects the trigger source: 1 = input A, 0 = input B. The other pin has no trigger effect.
  - A trigger-source edge that matches `cfg_trg_edge` sets the external-trigger flag (status bit 5).
  - That edge also resets the counter to zero on the next tick after the edge is acted on.
- R10: A software trigger pulse resets the counter to zero on the next tick after the pulse.
- R11: RC compare.
  - When the counter advances to the value of `rc_value`, the compare flag (status bit 2) is set.
  - With `cfg_rc_trig_en` set, that match also acts as a trigger, so the count runs 0 to RC and repeats.
  - With `cfg_rc_trig_en` clear, counting continues past RC.
- R12: Status flags are sticky until a `stat_clr` pulse clears all of them. A flag event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count tick from the selected count clock |
| pin_a | input | 1 | Input pin A (asynchronous) |
| pin_b | input | 1 | Input pin B (asynchronous) |
| sw_trig | input | 1 | Software trigger pulse |
| clk_en_cmd | input | 1 | Count clock enable pulse |
| clk_dis_cmd | input | 1 | Count clock disable pulse |
| cfg_ra_edge | input | 2 | Edge of A that loads RA |
| cfg_rb_edge | input | 2 | Edge of A that loads RB |
| cfg_trg_edge | input | 2 | Edge of the trigger source that triggers |
| cfg_trg_from_a | input | 1 | Trigger source select: 1 = A, 0 = B |
| cfg_rc_trig_en | input | 1 | RC compare acts as trigger |
| cfg_stop_on_rb | input | 1 | Freeze the counter after an RB load |
| cfg_dis_on_rb | input | 1 | Turn the clock off after an RB load |
| rc_value | input | CNT_W | Compare value RC |
| ra_rd | input | 1 | RA read strobe |
| rb_rd | input | 1 | RB read strobe |
| stat_clr | input | 1 | Clear all status flags |
| cnt | output | CNT_W | Counter value |
| ra_val | output | CNT_W | Capture register RA |
| rb_val | output | CNT_W | Capture register RB |
| clk_on | output | 1 | Count clock enabled |
| flags | output | 6 | Status flags: 0 overflow, 1 overrun, 2 compare, 3 RA, 4 RB, 5 trigger |

## Verification
The bench builds the channel with an 8-bit counter and a two-stage synchronizer. The narrow counter brings wraparound and the overflow flag within 256 ticks. The RC-compare period and the self-stop cases then take only a few dozen cycles. With the default synchronizer depth, every capture and external trigger lands exactly three edges after a pin change, so the captured values can be predicted from the counter reading taken when the pin is driven.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;

   localparam int FLAG_W    = 6;
   localparam int FLG_OVF   = 0;
   localparam int FLG_LOVR  = 1;
   localparam int FLG_RC    = 2;
   localparam int FLG_RA    = 3;
   localparam int FLG_RB    = 4;
   localparam int FLG_ETRG  = 5;

   function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
      case (sel)
         EDGE_RISE: edge_hit = rise;
         EDGE_FALL: edge_hit = fall;
         EDGE_BOTH: edge_hit = rise | fall;
         default:   edge_hit = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int CHAIN_W = STAGES + 1;

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-2:0], pin};
   end

   assign rise =  chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clk_en_cmd,
   input  logic             clk_dis_cmd,
   input  logic             trig_in,
   input  logic             rc_trig_en,
   input  logic             halt_now,
   input  logic             kill_now,
   input  logic [CNT_W-1:0] rc_value,
   output logic [CNT_W-1:0] cnt,
   output logic             clk_on,
   output logic             trig_pend,
   output logic             ovf_evt,
   output logic             rc_evt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             frozen;
   logic             adv;
   logic             zero_tick;
   logic             trig_any;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc   = cnt + CNT_ONE;
   assign zero_tick = tick & clk_on & trig_pend;
   assign adv       = tick & clk_on & ~frozen & ~halt_now & ~kill_now & ~trig_pend;
   assign ovf_evt   = adv & (cnt == CNT_MAX);
   assign rc_evt    = adv & (cnt_inc == rc_value);
   assign trig_any  = trig_in | (rc_evt & rc_trig_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         clk_on    <= 1'b0;
         frozen    <= 1'b0;
         trig_pend <= 1'b0;
      end else begin
         if (zero_tick)    cnt <= '0;
         else if (adv)     cnt <= cnt_inc;

         if (clk_dis_cmd || kill_now) clk_on <= 1'b0;
         else if (clk_en_cmd)         clk_on <= 1'b1;

         if (trig_any)      frozen <= 1'b0;
         else if (halt_now) frozen <= 1'b1;

         trig_pend <= trig_any | (trig_pend & ~zero_tick);
      end
   end
endmodule

// File: rtl/cap_capture_seq.sv
module cap_capture_seq
   import cap_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             a_rise,
   input  logic             a_fall,
   input  edge_sel_e        ra_edge,
   input  edge_sel_e        rb_edge,
   input  logic [CNT_W-1:0] cnt,
   input  logic             ra_rd,
   input  logic             rb_rd,
   output logic [CNT_W-1:0] ra_val,
   output logic [CNT_W-1:0] rb_val,
   output logic             ra_load,
   output logic             rb_load,
   output logic             ra_unread,
   output logic             lovr_evt
);
   logic want_b;
   logic rb_unread;

   assign ra_load  = active & ~want_b & edge_hit(ra_edge, a_rise, a_fall);
   assign rb_load  = active &  want_b & edge_hit(rb_edge, a_rise, a_fall);
   assign lovr_evt = (ra_load & ra_unread) | (rb_load & rb_unread);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra_val    <= '0;
         rb_val    <= '0;
         want_b    <= 1'b0;
         ra_unread <= 1'b0;
         rb_unread <= 1'b0;
      end else begin
         if (ra_load) ra_val <= cnt;
         if (rb_load) rb_val <= cnt;

         if (ra_load)      want_b <= 1'b1;
         else if (rb_load) want_b <= 1'b0;

         if (ra_load)    ra_unread <= 1'b1;
         else if (ra_rd) ra_unread <= 1'b0;

         if (rb_load)    rb_unread <= 1'b1;
         else if (rb_rd) rb_unread <= 1'b0;
      end
   end
endmodule

// File: rtl/cap_flag_bank.sv
module cap_flag_bank #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         clr,
   output logic [W-1:0] flags
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set[i] | (flags[i] & ~clr);
         end
      end
   endgenerate
endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
   import cap_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pin_a,
   input  logic              pin_b,
   input  logic              sw_trig,
   input  logic              clk_en_cmd,
   input  logic              clk_dis_cmd,
   input  logic [1:0]        cfg_ra_edge,
   input  logic [1:0]        cfg_rb_edge,
   input  logic [1:0]        cfg_trg_edge,
   input  logic              cfg_trg_from_a,
   input  logic              cfg_rc_trig_en,
   input  logic              cfg_stop_on_rb,
   input  logic              cfg_dis_on_rb,
   input  logic [CNT_W-1:0]  rc_value,
   input  logic              ra_rd,
   input  logic              rb_rd,
   input  logic              stat_clr,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  ra_val,
   output logic [CNT_W-1:0]  rb_val,
   output logic              clk_on,
   output logic [FLAG_W-1:0] flags
);
   localparam int NPINS = 2;

   initial begin
      if (CNT_W < 2 || CNT_W > 32) $fatal(1, "CNT_W must lie in 2..32");
      if (SYNC_STAGES < 2)         $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0]  pins_in;
   logic [NPINS-1:0]  rise_v;
   logic [NPINS-1:0]  fall_v;
   logic              trg_rise;
   logic              trg_fall;
   logic              ext_trig;
   logic              ra_load;
   logic              rb_load;
   logic              ra_unread;
   logic              lovr_evt;
   logic              trig_pend;
   logic              ovf_evt;
   logic              rc_evt;
   logic              halt_now;
   logic              kill_now;
   logic [FLAG_W-1:0] flag_set;

   assign pins_in = {pin_b, pin_a};

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins_in[p]),
            .rise (rise_v[p]),
            .fall (fall_v[p])
         );
      end
   endgenerate

   assign trg_rise = cfg_trg_from_a ? rise_v[0] : rise_v[1];
   assign trg_fall = cfg_trg_from_a ? fall_v[0] : fall_v[1];
   assign ext_trig = edge_hit(edge_sel_e'(cfg_trg_edge), trg_rise, trg_fall);

   assign halt_now = rb_load & cfg_stop_on_rb;
   assign kill_now = rb_load & cfg_dis_on_rb;

   cap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .clk_en_cmd (clk_en_cmd),
      .clk_dis_cmd(clk_dis_cmd),
      .trig_in    (sw_trig | ext_trig),
      .rc_trig_en (cfg_rc_trig_en),
      .halt_now   (halt_now),
      .kill_now   (kill_now),
      .rc_value   (rc_value),
      .cnt        (cnt),
      .clk_on     (clk_on),
      .trig_pend  (trig_pend),
      .ovf_evt    (ovf_evt),
      .rc_evt     (rc_evt)
   );

   cap_capture_seq #(.CNT_W(CNT_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (clk_on),
      .a_rise   (rise_v[0]),
      .a_fall   (fall_v[0]),
      .ra_edge  (edge_sel_e'(cfg_ra_edge)),
      .rb_edge  (edge_sel_e'(cfg_rb_edge)),
      .cnt      (cnt),
      .ra_rd    (ra_rd),
      .rb_rd    (rb_rd),
      .ra_val   (ra_val),
      .rb_val   (rb_val),
      .ra_load  (ra_load),
      .rb_load  (rb_load),
      .ra_unread(ra_unread),
      .lovr_evt (lovr_evt)
   );

   always_comb begin
      flag_set           = '0;
      flag_set[FLG_OVF]  = ovf_evt;
      flag_set[FLG_LOVR] = lovr_evt;
      flag_set[FLG_RC]   = rc_evt;
      flag_set[FLG_RA]   = ra_load;
      flag_set[FLG_RB]   = rb_load;
      flag_set[FLG_ETRG] = ext_trig;
   end

   cap_flag_bank #(.W(FLAG_W)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set),
      .clr  (stat_clr),
      .flags(flags)
   );
endmodule

// File: rtl/cap_timer_chan_chk.sv
module cap_timer_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             clk_dis_cmd,
   input logic             cfg_dis_on_rb,
   input logic             stat_clr,
   input logic             clk_on,
   input logic [CNT_W-1:0] cnt,
   input logic [5:0]       flags,
   input logic             ra_load,
   input logic             rb_load,
   input logic             ra_unread,
   input logic             trig_pend
);
   assert_dis_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_dis_cmd |=> !clk_on);

   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   assert_ovf_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> (cnt == '0));

   assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ra_load |=> !ra_load);

   assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_load && ra_unread) |=> flags[1]);

   assert_dis_on_rb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_load && cfg_dis_on_rb) |=> !clk_on);

   assert_trig_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_pend && tick && clk_on) |=> (cnt == '0));

   assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind cap_timer_chan cap_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_cap_timer_chan.sv
`timescale 1ns/1ps
module tb_cap_timer_chan;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         tick, pin_a, pin_b, sw_trig, clk_en_cmd, clk_dis_cmd;
   logic [1:0]   cfg_ra_edge, cfg_rb_edge, cfg_trg_edge;
   logic         cfg_trg_from_a, cfg_rc_trig_en, cfg_stop_on_rb, cfg_dis_on_rb;
   logic [W-1:0] rc_value;
   logic         ra_rd, rb_rd, stat_clr;
   logic [W-1:0] cnt, ra_val, rb_val;
   logic         clk_on;
   logic [5:0]   flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cap_timer_chan #(.CNT_W(W), .SYNC_STAGES(2)) dut (.*);

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic reset_dut();
      rst_n = 1'b0;
      tick = 1'b1; pin_a = 1'b0; pin_b = 1'b0; sw_trig = 1'b0;
      clk_en_cmd = 1'b0; clk_dis_cmd = 1'b0;
      cfg_ra_edge = 2'd0; cfg_rb_edge = 2'd0; cfg_trg_edge = 2'd0;
      cfg_trg_from_a = 1'b0; cfg_rc_trig_en = 1'b0;
      cfg_stop_on_rb = 1'b0; cfg_dis_on_rb = 1'b0;
      rc_value = '0; ra_rd = 1'b0; rb_rd = 1'b0; stat_clr = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic enable_clk();
      clk_en_cmd = 1'b1;
      cyc(1);
      clk_en_cmd = 1'b0;
   endtask

   task automatic pulse_a();
      pin_a = 1'b1; cyc(3);
      pin_a = 1'b0; cyc(3);
   endtask

   task automatic t_reset();
      reset_dut();
      chk("R1", "cnt", cnt, 0);
      chk("R1", "ra", ra_val, 0);
      chk("R1", "rb", rb_val, 0);
      chk("R1", "flags", flags, 0);
      chk("R1", "clk_on", clk_on, 0);
   endtask

   task automatic t_count();
      reset_dut();
      enable_clk();
      chk("R2", "cnt after enable", cnt, 0);
      chk("R2", "clk_on", clk_on, 1);
      cyc(5);
      chk("R2", "cnt after 5 ticks", cnt, 5);
      tick = 1'b0; cyc(3);
      chk("R2", "cnt hold without tick", cnt, 5);
      clk_en_cmd = 1'b1; clk_dis_cmd = 1'b1; cyc(1);
      clk_en_cmd = 1'b0; clk_dis_cmd = 1'b0;
      chk("R2", "disable wins", clk_on, 0);
      tick = 1'b1; cyc(3);
      chk("R2", "cnt hold while off", cnt, 5);
   endtask

   task automatic t_overflow();
      reset_dut();
      enable_clk();
      cyc(255);
      chk("R3", "cnt at max", cnt, 255);
      chk("R3", "no ovf yet", flags[0], 0);
      cyc(1);
      chk("R3", "wrap to zero", cnt, 0);
      chk("R3", "ovf flag", flags[0], 1);
   endtask

   task automatic t_edges();
      int c;
      reset_dut();
      enable_clk();
      pin_a = 1'b1; cyc(3);
      chk("R4", "edge none ignored flag", flags[3], 0);
      chk("R4", "edge none ignored ra", ra_val, 0);
      pin_a = 1'b0; cyc(3);
      cfg_ra_edge = 2'd2;
      pin_a = 1'b1; cyc(3);
      chk("R4", "falling ignores rise", flags[3], 0);
      c = cnt;
      pin_a = 1'b0; cyc(3);
      chk("R5", "ra loaded flag", flags[3], 1);
      chk("R5", "ra value on fall", ra_val, c + 2);
      reset_dut();
      cfg_ra_edge = 2'd3; cfg_rb_edge = 2'd3;
      enable_clk();
      cyc(2);
      c = cnt;
      pin_a = 1'b1; cyc(3);
      chk("R4", "both: ra on rise", ra_val, c + 2);
      c = cnt;
      pin_a = 1'b0; cyc(3);
      chk("R4", "both: rb on fall", rb_val, c + 2);
   endtask

   task automatic t_alternate();
      int c, c2;
      reset_dut();
      cfg_ra_edge = 2'd1; cfg_rb_edge = 2'd1;
      enable_clk();
      cyc(4);
      c = cnt;
      pin_a = 1'b1; cyc(3);
      chk("R6", "first rise loads ra", ra_val, c + 2);
      chk("R6", "first rise leaves rb", rb_val, 0);
      chk("R6", "rb flag clear", flags[4], 0);
      pin_a = 1'b0; cyc(3);
      c2 = cnt;
      pin_a = 1'b1; cyc(3);
      chk("R6", "second rise loads rb", rb_val, c2 + 2);
      chk("R6", "second rise leaves ra", ra_val, c + 2);
      chk("R6", "rb flag set", flags[4], 1);
   endtask

   task automatic t_overrun();
      reset_dut();
      cfg_ra_edge = 2'd1; cfg_rb_edge = 2'd1;
      enable_clk();
      pulse_a();
      pulse_a();
      chk("R7", "no overrun after ra,rb", flags[1], 0);
      pulse_a();
      chk("R7", "unread ra reloaded", flags[1], 1);
      stat_clr = 1'b1; cyc(1); stat_clr = 1'b0;
      chk("R12", "clear all flags", flags, 0);
      rb_rd = 1'b1; cyc(1); rb_rd = 1'b0;
      pulse_a();
      chk("R7", "rb read before reload", flags[1], 0);
      chk("R7", "rb reloaded", flags[4], 1);
   endtask

   task automatic t_stop_rb();
      int c;
      reset_dut();
      cfg_ra_edge = 2'd1; cfg_rb_edge = 2'd2; cfg_stop_on_rb = 1'b1;
      enable_clk();
      cyc(3);
      pin_a = 1'b1; cyc(3);
      c = cnt;
      pin_a = 1'b0; cyc(3);
      chk("R8", "stop: rb value", rb_val, c + 2);
      chk("R8", "stop: cnt frozen", cnt, c + 2);
      cyc(5);
      chk("R8", "stop: still frozen", cnt, c + 2);
      chk("R8", "stop: clock stays on", clk_on, 1);
      sw_trig = 1'b1; cyc(1); sw_trig = 1'b0; cyc(1);
      chk("R10", "trigger restarts at 0", cnt, 0);
      cyc(2);
      chk("R10", "counting after restart", cnt, 2);

      reset_dut();
      cfg_ra_edge = 2'd1; cfg_rb_edge = 2'd2; cfg_dis_on_rb = 1'b1;
      enable_clk();
      cyc(3);
      pin_a = 1'b1; cyc(3);
      c = cnt;
      pin_a = 1'b0; cyc(3);
      chk("R8", "dis: clock off", clk_on, 0);
      chk("R8", "dis: cnt held", cnt, c + 2);
      cyc(4);
      chk("R8", "dis: still held", cnt, c + 2);
   endtask

   task automatic t_ext_trig();
      reset_dut();
      cfg_trg_edge = 2'd1; cfg_trg_from_a = 1'b0;
      enable_clk();
      cyc(20);
      pin_a = 1'b1; cyc(5);
      chk("R9", "pin A ignored as source", cnt, 25);
      chk("R9", "no trigger flag from A", flags[5], 0);
      pin_b = 1'b1; cyc(3);
      chk("R9", "cnt before reset", cnt, 28);
      chk("R9", "trigger flag", flags[5], 1);
      cyc(1);
      chk("R9", "reset to zero", cnt, 0);
      cyc(2);
      cfg_trg_edge = 2'd0; pin_b = 1'b0; cyc(4);
      chk("R9", "edge none no reset", cnt, 6);
   endtask

   task automatic t_sw_trig();
      reset_dut();
      enable_clk();
      cyc(10);
      sw_trig = 1'b1; cyc(1); sw_trig = 1'b0;
      chk("R10", "cnt before reset", cnt, 11);
      cyc(1);
      chk("R10", "sw trig zero", cnt, 0);
   endtask

   task automatic t_rc();
      reset_dut();
      rc_value = 8'd10; cfg_rc_trig_en = 1'b1;
      enable_clk();
      cyc(10);
      chk("R11", "cnt at rc", cnt, 10);
      chk("R11", "rc flag", flags[2], 1);
      cyc(1);
      chk("R11", "rc reset", cnt, 0);
      cyc(10);
      chk("R11", "period repeats", cnt, 10);
      cfg_rc_trig_en = 1'b0;
      cyc(1);
      chk("R11", "pending reset", cnt, 0);
      cyc(11);
      chk("R11", "runs past rc", cnt, 11);
      chk("R12", "rc flag sticky", flags[2], 1);
      stat_clr = 1'b1; cyc(1); stat_clr = 1'b0;
      chk("R12", "clear", flags, 0);
   endtask

   initial begin
      t_reset();
      t_count();
      t_overflow();
      t_edges();
      t_alternate();
      t_overrun();
      t_stop_rb();
      t_ext_trig();
      t_sw_trig();
      t_rc();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule